// File: doc/BRIEF.md
# Banked Register File with Priority-Driven Set Switching

This block is the general-purpose register storage of a processor core. It holds several complete copies of the register array, called sets. Instructions only ever see one set, the active one. When an interrupt is accepted, the file switches to a set picked for the interrupt's priority level. The handler then runs in fresh registers and does not have to save the interrupted program's registers to memory first.

The file remembers which set was active before the switch. Two cross-set moves use that record. The first pulls one register out of the remembered set into the active set. A handler uses it to pick up the interrupted program's stack pointer. The second pushes one register from the active set back into the remembered set, which a handler does just before it returns. A return pulse makes the remembered set active again and restores the old priority level. A small table, written by the core, decides which set each priority level uses. Only one level of interrupt is tracked at a time.

Sizes are fixed in the package: 4 sets of 32 registers of 32 bits, and 8 priority levels.

Top module: `bank_switch_rf`

## Requirements
- R1: After reset the current set, previous set, current level and in-service flag are all 0. Every register of every set reads 0. Map entry for level i holds set i mod 4.
- R2: Register 0 reads 0 in every set. Any write aimed at register 0 is dropped, including both cross-set moves.
- R3: With `wrEn` high and `xferOp` at 00 or 11, `wrData` is stored into `wrAddr` of the current set on the rising edge. Both read ports return the current set's contents combinationally.
- R4: If a read port addresses the register that is being written in the current set during the same cycle, it returns the value being written. Register 0 is the exception.
- R5: An interrupt is accepted, and `irqAccept` is high, only when `irqReq` is high, no interrupt is in service, and `irqLevel` is strictly greater than the current level.
- R6: On the edge after acceptance, the previous set takes the old current set, the current set takes the map entry for `irqLevel`, the old level is saved, the current level becomes `irqLevel`, and the in-service flag is set. A register write in the accepting cycle still lands in the old set.
- R7: With `mapWe` high, `mapSet` is stored into the map entry for `mapLevel` on the rising edge. An acceptance in that same cycle still uses the old entry.
- R8: With `xferOp` = 01, register `xferSrc` of the previous set is copied into register `xferDst` of the current set, and `wrEn` is ignored. The copied value is bypassed to same-cycle reads as in R4.
- R9: With `xferOp` = 10, register `xferSrc` of the current set is copied into register `xferDst` of the previous set, and `wrEn` is ignored. The current set is not changed.
- R10: An `eret` pulse while in service restores the current set from the previous set and the current level from the saved level, and clears in-service. An `eret` pulse while not in service has no effect.
- R11: While an interrupt is in service, further requests are not accepted at any level. A request still held after the return is accepted if it meets R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 32 | Read port A data from the current set |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 32 | Read port B data from the current set |
| wrEn | input | 1 | Normal write enable |
| wrAddr | input | 5 | Normal write register number |
| wrData | input | 32 | Normal write data |
| xferOp | input | 2 | Cross-set move: 00 none, 01 previous to current, 10 current to previous, 11 none |
| xferDst | input | 5 | Destination register of a cross-set move |
| xferSrc | input | 5 | Source register of a cross-set move |
| irqReq | input | 1 | Interrupt request |
| irqLevel | input | 3 | Requested priority level |
| irqAccept | output | 1 | High in the cycle an interrupt is accepted |
| eret | input | 1 | Return-from-interrupt pulse |
| mapWe | input | 1 | Level-to-set map write enable |
| mapLevel | input | 3 | Map entry to write |
| mapSet | input | 2 | Set number to store |
| curSet | output | 2 | Currently active set |
| prevSet | output | 2 | Set active before the last acceptance |
| curLevel | output | 3 | Current priority level |
| inService | output | 1 | An interrupt is being serviced |

## Verification
Read data and `irqAccept` are combinational, so both are due in the same cycle as the inputs that cause them. Register writes, cross-set moves, set and level changes and map writes appear one rising edge later. The bench drives all inputs just after a falling edge. It compares the combinational outputs a nanosecond later against a model that still holds the pre-edge state. Only after that does it advance the model, so state results are compared in the following cycle. This matches the one registered stage on each of those paths.

// File: rtl/bank_switch_pkg.sv
package bank_switch_pkg;
  localparam int SETS   = 4;
  localparam int REGS   = 32;
  localparam int XLEN   = 32;
  localparam int LEVELS = 8;

  localparam int SET_W  = $clog2(SETS);
  localparam int ADDR_W = $clog2(REGS);
  localparam int LVL_W  = $clog2(LEVELS);

  typedef enum logic [1:0] {
    XFER_NONE   = 2'b00,
    XFER_PULL   = 2'b01,
    XFER_PUSH   = 2'b10,
    XFER_RSVD   = 2'b11
  } xfer_e;

  // strobes from control to datapath for the single write port
  typedef struct packed {
    logic              we;
    logic [SET_W-1:0]  wrSet;
    logic [ADDR_W-1:0] wrAddr;
    logic              useSrc;
    logic [SET_W-1:0]  srcSet;
    logic [ADDR_W-1:0] srcAddr;
  } dpCtl_t;
endpackage

// File: rtl/bank_switch_ctrl.sv
module bank_switch_ctrl
  import bank_switch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        xferOp,
  input  logic [ADDR_W-1:0] xferDst,
  input  logic [ADDR_W-1:0] xferSrc,
  input  logic              irqReq,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              eret,
  input  logic              mapWe,
  input  logic [LVL_W-1:0]  mapLevel,
  input  logic [SET_W-1:0]  mapSet,
  output dpCtl_t            dpCtl,
  output logic [SET_W-1:0]  curSet,
  output logic [SET_W-1:0]  prevSet,
  output logic [LVL_W-1:0]  curLevel,
  output logic              inService,
  output logic              irqAccept
);
  logic [SET_W-1:0] mapTbl [LEVELS];
  logic [SET_W-1:0] curSetQ, prevSetQ, mappedSet;
  logic [LVL_W-1:0] curLvl, savedLvl;
  logic             inSvc, accept, leave;
  xfer_e            op;

  assign op        = xfer_e'(xferOp);
  assign mappedSet = mapTbl[irqLevel];
  assign accept    = irqReq && !inSvc && (irqLevel > curLvl);
  assign leave     = eret && inSvc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSetQ  <= '0;
      prevSetQ <= '0;
      curLvl   <= '0;
      savedLvl <= '0;
      inSvc    <= 1'b0;
      for (int i = 0; i < LEVELS; i++) mapTbl[i] <= SET_W'(i % SETS);
    end else begin
      if (leave) begin
        curSetQ <= prevSetQ;
        curLvl  <= savedLvl;
        inSvc   <= 1'b0;
      end else if (accept) begin
        prevSetQ <= curSetQ;
        curSetQ  <= mappedSet;
        savedLvl <= curLvl;
        curLvl   <= irqLevel;
        inSvc    <= 1'b1;
      end
      if (mapWe) mapTbl[mapLevel] <= mapSet;
    end
  end

  always_comb begin
    dpCtl = '0;
    unique case (op)
      XFER_PULL: begin
        dpCtl.we      = 1'b1;
        dpCtl.wrSet   = curSetQ;
        dpCtl.wrAddr  = xferDst;
        dpCtl.useSrc  = 1'b1;
        dpCtl.srcSet  = prevSetQ;
        dpCtl.srcAddr = xferSrc;
      end
      XFER_PUSH: begin
        dpCtl.we      = 1'b1;
        dpCtl.wrSet   = prevSetQ;
        dpCtl.wrAddr  = xferDst;
        dpCtl.useSrc  = 1'b1;
        dpCtl.srcSet  = curSetQ;
        dpCtl.srcAddr = xferSrc;
      end
      default: begin
        dpCtl.we     = wrEn;
        dpCtl.wrSet  = curSetQ;
        dpCtl.wrAddr = wrAddr;
      end
    endcase
  end

  assign curSet    = curSetQ;
  assign prevSet   = prevSetQ;
  assign curLevel  = curLvl;
  assign inService = inSvc;
  assign irqAccept = accept;

  // R6
  accept_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> inSvc && curSetQ == $past(mappedSet) && prevSetQ == $past(curSetQ)
               && curLvl == $past(irqLevel) && savedLvl == $past(curLvl));

  // R10
  return_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eret && inSvc) |=> !inSvc && curSetQ == $past(prevSetQ) && curLvl == $past(savedLvl));

  // R11
  nest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSvc && !eret) |=> inSvc && $stable(curSetQ) && $stable(curLvl));

  // R5
  level_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSvc) |-> curLvl > $past(curLvl));
endmodule

// File: rtl/bank_switch_dp.sv
module bank_switch_dp
  import bank_switch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [SET_W-1:0]  curSet,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [XLEN-1:0]   wrData,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB
);
  localparam int NPORTS = 2;

  logic [XLEN-1:0]   regs [SETS][REGS];
  logic [XLEN-1:0]   srcVal, wrVal;
  logic [ADDR_W-1:0] rdAddr [NPORTS];
  logic [XLEN-1:0]   rdData [NPORTS];
  logic              wrLive;

  assign srcVal = (dpCtl.srcAddr == '0) ? '0 : regs[dpCtl.srcSet][dpCtl.srcAddr];
  assign wrVal  = dpCtl.useSrc ? srcVal : wrData;
  assign wrLive = dpCtl.we && (dpCtl.wrAddr != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int r = 0; r < REGS; r++) regs[s][r] <= '0;
    end else if (wrLive) begin
      regs[dpCtl.wrSet][dpCtl.wrAddr] <= wrVal;
    end
  end

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    always_comb begin
      if (rdAddr[p] == '0)
        rdData[p] = '0;
      else if (wrLive && dpCtl.wrSet == curSet && dpCtl.wrAddr == rdAddr[p])
        rdData[p] = wrVal;
      else
        rdData[p] = regs[curSet][rdAddr[p]];
    end

    // R2
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr[p] == '0) |-> (rdData[p] == '0));
  end

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
endmodule

// File: rtl/bank_switch_rf.sv
module bank_switch_rf
  import bank_switch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [XLEN-1:0]   rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData,
  input  logic [1:0]        xferOp,
  input  logic [ADDR_W-1:0] xferDst,
  input  logic [ADDR_W-1:0] xferSrc,
  input  logic              irqReq,
  input  logic [LVL_W-1:0]  irqLevel,
  output logic              irqAccept,
  input  logic              eret,
  input  logic              mapWe,
  input  logic [LVL_W-1:0]  mapLevel,
  input  logic [SET_W-1:0]  mapSet,
  output logic [SET_W-1:0]  curSet,
  output logic [SET_W-1:0]  prevSet,
  output logic [LVL_W-1:0]  curLevel,
  output logic              inService
);
  dpCtl_t ctlBus;

  bank_switch_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .xferOp(xferOp), .xferDst(xferDst), .xferSrc(xferSrc),
    .irqReq(irqReq), .irqLevel(irqLevel), .eret(eret),
    .mapWe(mapWe), .mapLevel(mapLevel), .mapSet(mapSet),
    .dpCtl(ctlBus), .curSet(curSet), .prevSet(prevSet),
    .curLevel(curLevel), .inService(inService), .irqAccept(irqAccept)
  );

  bank_switch_dp dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(ctlBus), .curSet(curSet),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: tb/bank_switch_rf_tb_top.sv
`timescale 1ns/1ps
module bank_switch_rf_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0, xferDst = '0, xferSrc = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, irqReq = 1'b0, eret = 1'b0, mapWe = 1'b0;
  logic [1:0]  xferOp = '0, mapSet = '0;
  logic [2:0]  irqLevel = '0, mapLevel = '0;
  logic        irqAccept, inService;
  logic [1:0]  curSet, prevSet;
  logic [2:0]  curLevel;

  int nChk = 0, nBad = 0;
  bit done = 0;

  // reference state
  logic [31:0] mdl [4][32];
  logic [1:0]  mCur, mPrev, mMap [8];
  logic [2:0]  mLvl, mSaved;
  bit          mIn;

  always #4 clk = ~clk;

  bank_switch_rf dut_i (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [4:0] a, bit we, logic [1:0] ws,
                                          logic [4:0] wa, logic [31:0] wv);
    if (a == 0) return 32'h0;
    if (we && wa != 0 && ws == mCur && wa == a) return wv;
    return mdl[mCur][a];
  endfunction

  task automatic cycle(string tag, bit wen, logic [4:0] wa, logic [31:0] wd,
                       logic [4:0] ra, logic [4:0] rb, logic [1:0] xop,
                       logic [4:0] xd, logic [4:0] xs, bit irq, logic [2:0] lv,
                       bit er, bit mwe, logic [2:0] ml, logic [1:0] ms);
    bit eWe, eAcc;
    logic [1:0]  eWs;
    logic [4:0]  eWa;
    logic [31:0] eWv;
    @(negedge clk);
    wrEn = wen; wrAddr = wa; wrData = wd; rdAddrA = ra; rdAddrB = rb;
    xferOp = xop; xferDst = xd; xferSrc = xs; irqReq = irq; irqLevel = lv;
    eret = er; mapWe = mwe; mapLevel = ml; mapSet = ms;
    #1;
    if (xop == 2'b01) begin
      eWe = 1; eWs = mCur; eWa = xd; eWv = (xs == 0) ? 32'h0 : mdl[mPrev][xs];
    end else if (xop == 2'b10) begin
      eWe = 1; eWs = mPrev; eWa = xd; eWv = (xs == 0) ? 32'h0 : mdl[mCur][xs];
    end else begin
      eWe = wen; eWs = mCur; eWa = wa; eWv = wd;
    end
    eAcc = irq && !mIn && (lv > mLvl);
    chk(tag, "rdDataA", rdDataA, expRead(ra, eWe, eWs, eWa, eWv));
    chk(tag, "rdDataB", rdDataB, expRead(rb, eWe, eWs, eWa, eWv));
    chk(tag, "curSet", 32'(curSet), 32'(mCur));
    chk(tag, "prevSet", 32'(prevSet), 32'(mPrev));
    chk(tag, "curLevel", 32'(curLevel), 32'(mLvl));
    chk(tag, "inService", 32'(inService), 32'(mIn));
    chk(tag, "irqAccept", 32'(irqAccept), 32'(eAcc));
    // advance the model past the coming rising edge
    if (eWe && eWa != 0) mdl[eWs][eWa] = eWv;
    if (er && mIn) begin
      mCur = mPrev; mLvl = mSaved; mIn = 0;
    end else if (eAcc) begin
      mPrev = mCur; mCur = mMap[lv]; mSaved = mLvl; mLvl = lv; mIn = 1;
    end
    if (mwe) mMap[ml] = ms;
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < 4; s++) for (int r = 0; r < 32; r++) mdl[s][r] = 32'h0;
    for (int i = 0; i < 8; i++) mMap[i] = 2'(i % 4);
    mCur = 0; mPrev = 0; mLvl = 0; mSaved = 0; mIn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state and zeroed storage
    cycle("R1", 0,0,0, 5'd29, 5'd31, 2'b00,0,0, 0,0, 0, 0,0,0);
    cycle("R1", 0,0,0, 5'd1, 5'd17, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R3 normal write then read back
    cycle("R3", 1,5'd29,32'h0000_1000, 5'd3, 5'd4, 2'b00,0,0, 0,0, 0, 0,0,0);
    cycle("R3", 0,0,0, 5'd29, 5'd3, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R2 write to register 0 dropped
    cycle("R2", 1,5'd0,32'hDEAD_BEEF, 5'd0, 5'd0, 2'b00,0,0, 0,0, 0, 0,0,0);
    cycle("R2", 0,0,0, 5'd0, 5'd29, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R4 same-cycle bypass on both ports
    cycle("R4", 1,5'd5,32'h1234_5678, 5'd5, 5'd5, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R5 equal level refused
    cycle("R5", 0,0,0, 5'd5, 5'd0, 2'b00,0,0, 1,3'd0, 0, 0,0,0);
    // R6 accept level 3 (reset map -> set 3), write in same cycle lands in set 0
    cycle("R6", 1,5'd6,32'h0000_0066, 5'd6, 5'd29, 2'b00,0,0, 1,3'd3, 0, 0,0,0);
    cycle("R6", 0,0,0, 5'd6, 5'd29, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R8 pull stack pointer from previous set, with bypass
    cycle("R8", 1,5'd9,32'hFFFF_FFFF, 5'd29, 5'd9, 2'b01,5'd29,5'd29, 0,0, 0, 0,0,0);
    cycle("R8", 0,0,0, 5'd29, 5'd9, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R11 higher request held while in service
    cycle("R11", 0,0,0, 5'd29, 5'd0, 2'b00,0,0, 1,3'd5, 0, 0,0,0);
    cycle("R11", 1,5'd7,32'h0000_00AB, 5'd7, 5'd0, 2'b00,0,0, 1,3'd7, 0, 0,0,0);
    // R9 push register 7 of active set into register 9 of previous set
    cycle("R9", 1,5'd7,32'h5555_5555, 5'd7, 5'd9, 2'b10,5'd9,5'd7, 0,0, 0, 0,0,0);
    cycle("R9", 0,0,0, 5'd7, 5'd9, 2'b10,5'd0,5'd7, 0,0, 0, 0,0,0);
    // R10 return, then request (level 5) accepted afterwards (R11)
    cycle("R10", 0,0,0, 5'd9, 5'd6, 2'b00,0,0, 1,3'd5, 1, 0,0,0);
    cycle("R11", 0,0,0, 5'd9, 5'd6, 2'b00,0,0, 1,3'd5, 0, 0,0,0);
    cycle("R10", 0,0,0, 5'd9, 5'd6, 2'b00,0,0, 0,0, 1, 0,0,0);
    // R10 stray return ignored
    cycle("R10", 0,0,0, 5'd9, 5'd29, 2'b00,0,0, 0,0, 1, 0,0,0);
    cycle("R10", 0,0,0, 5'd9, 5'd29, 2'b00,0,0, 0,0, 0, 0,0,0);
    // R7 remap level 6 to set 2; same-cycle accept uses old entry
    cycle("R7", 0,0,0, 5'd1, 5'd2, 2'b00,0,0, 1,3'd6, 0, 1,3'd6,2'd2);
    cycle("R7", 0,0,0, 5'd1, 5'd2, 2'b00,0,0, 0,0, 1, 0,0,0);
    cycle("R7", 0,0,0, 5'd1, 5'd2, 2'b00,0,0, 1,3'd6, 0, 0,0,0);
    cycle("R7", 0,0,0, 5'd1, 5'd2, 2'b00,0,0, 0,0, 1, 0,0,0);
    cycle("R7", 0,0,0, 5'd1, 5'd2, 2'b00,0,0, 0,0, 0, 0,0,0);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] xop;
      int pick;
      pick = $urandom % 8;
      xop  = (pick == 0) ? 2'b01 : (pick == 1) ? 2'b10 : (pick == 2) ? 2'b11 : 2'b00;
      cycle(xop == 2'b01 ? "R8" : xop == 2'b10 ? "R9" : "R3",
            ($urandom % 2) == 0, 5'($urandom), $urandom,
            5'($urandom), 5'($urandom % 8), xop, 5'($urandom), 5'($urandom % 8),
            ($urandom % 4) == 0, 3'($urandom), ($urandom % 6) == 0,
            ($urandom % 16) == 0, 3'($urandom), 2'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule